// File: doc/BRIEF.md
# Block-Compressed Speculative Branch History Register

This block keeps the global branch history that feeds a wide front end's direction predictor. Up to two fetch blocks of up to eight instructions arrive each cycle. Each block adds at most one bit to the history. That bit is the direction of the block's final conditional branch, flipped when the branch sits in the upper half of the block. Any earlier conditional branch in the block is taken to be not taken, so it adds nothing. A block with no conditional branch adds no bit.

The predictor needs its index a few cycles before the youngest blocks have resolved. For that reason the history presented on `hist_out` leaves out the three most recent fetch blocks. For those three blocks, the low-order address bits are presented on `path_out` in their place. A block enters a three-deep recent window first. Its bit moves into the history only when a later fetch block pushes it out of that window.

Misprediction repair uses one checkpoint. `snap_take` copies the whole live state: the history and the recent window. `snap_restore` reloads that copy in a single cycle.

Top module: `shr_block_hist`

## Requirements
- R1: While `rst_n` is low at a rising edge, `hist_out` and `path_out` become all zeros on that edge. The checkpoint copy is also cleared.
- R2: The bit a block contributes is `taken XOR upper`. `upper` is 1 when the block's last-branch slot is 4 or more, which is the upper half of the 8-slot block (slot field 3 bits per block, slot 0 in bits [2:0]). For example, taken at slot 2 gives 1, taken at slot 5 gives 0, and not taken at slot 7 gives 1.
- R3: A valid block whose has-conditional flag is 0 adds no history bit, but it still takes one place in the recent window and delays older blocks' bits.
- R4: A cycle with no valid block and no restore leaves `hist_out` and `path_out` unchanged.
- R5: A block's bit appears at `hist_out[0]` only in the cycle after the third later fetch block has arrived. Until then it is absent from `hist_out`.
- R6: When both slots are valid in one cycle, slot 0 is the older block: its entry goes into the window first, and bits leaving the window go into the history in age order, so 0, 1 or 2 bits enter per cycle.
- R7: `path_out` carries 2 address bits per recent block: bits [1:0] hold the most recent block, [3:2] the previous one and [5:4] the one before that. `blk_pc_lo[1:0]` belongs to slot 0 and `[3:2]` to slot 1.
- R8: History is `HIST_LEN` bits (21 by default). The newest bit enters at bit 0 and the oldest bit falls off bit `HIST_LEN-1`.
- R9: `snap_restore` reloads the checkpointed history and window on the next edge, and any valid blocks in that cycle are ignored.
- R10: `snap_take` copies the live state as it was before the current edge's update. When `snap_take` and `snap_restore` are both high, the restore uses the previous copy and the new copy holds the pre-edge live state.
- R11: When only slot 1 is valid, it is handled as a single block in the same way as a lone slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_valid | input | 2 | Per-slot fetch block present; slot 0 is older |
| blk_has_cond | input | 2 | Per-slot: block contains a conditional branch |
| blk_last_slot | input | 6 | Per-slot instruction position of the last conditional branch |
| blk_taken | input | 2 | Per-slot direction of that last conditional branch |
| blk_pc_lo | input | 4 | Per-slot low block-address bits used as path information |
| snap_take | input | 1 | Copy live state into the checkpoint |
| snap_restore | input | 1 | Reload live state from the checkpoint |
| hist_out | output | 21 | Compressed history excluding the three newest blocks, newest at bit 0 |
| path_out | output | 6 | Address bits of the three newest blocks, newest at bits [1:0] |

## Verification
Every output is registered. Inputs presented in one cycle therefore show on `path_out` and on a restored `hist_out` right after the next rising edge. A block's own history bit reaches `hist_out` only after the edge on which the third younger block arrives. The bench drives inputs just after a falling edge and compares both outputs at the following falling edge against a reference model that moves blocks through a three-place window. Directed checks cover the exact cycle a bit is still missing and the cycle it first appears (R5), as well as the restore cycle and the cycle where a snapshot and a restore coincide.

// File: rtl/hb_pkg.sv
// Shared definitions for the block-compressed history register.
// Assumes exactly two fetch slots per cycle and a fixed three-block lag.
package hb_pkg;
    localparam int unsigned HB_LAG   = 3;
    localparam int unsigned HB_SLOTS = 2;

    // How many fetch blocks advance the recent window this cycle
    typedef enum logic [1:0] {
        ADV_NONE = 2'd0,
        ADV_ONE  = 2'd1,
        ADV_TWO  = 2'd2
    } hb_adv_e;
endpackage

// File: rtl/hb_fold.sv
// Folds one fetch block into its single history bit.
// Assumes the block spans 2**SLOT_W instruction slots; the upper half starts
// at slot 2**(SLOT_W-1).
module hb_fold #(
    parameter int unsigned SLOT_W = 3
) (
    input  logic              has_cond,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic              taken,
    output logic              has_bit,
    output logic              fold_bit
);
    localparam logic [SLOT_W-1:0] HALF = SLOT_W'(1) << (SLOT_W - 1);

    logic upper_half;

    // Position of the last branch relative to the block midpoint
    always_comb upper_half = (last_slot >= HALF);

    // Direction flipped by half-block position; present only with a branch
    always_comb begin
        has_bit  = has_cond;
        fold_bit = taken ^ upper_half;
    end
endmodule

// File: rtl/hb_checkpoint.sv
// Single-entry checkpoint of the full live state.
// Assumes the caller applies a restore from the value held before this edge.
module hb_checkpoint #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] live_state,
    output logic [W-1:0] saved_state
);
    // Capture the pre-edge live state when requested
    always_ff @(posedge clk) begin
        if (!rst_n)
            saved_state <= '0;
        else if (take)
            saved_state <= live_state;
    end
endmodule

// File: rtl/hb_window.sv
// Recent-block window plus retired history.
// Entry 0 is the newest block. When blocks arrive, the oldest entries leave
// the window and, if they carry a bit, shift into the history at bit 0.
// Assumes LAG >= 3 and HIST_LEN >= 2.
module hb_window
    import hb_pkg::*;
#(
    parameter int unsigned HIST_LEN  = 21,
    parameter int unsigned PATH_BITS = 2,
    parameter int unsigned LAG       = HB_LAG,
    localparam int unsigned PW       = LAG * PATH_BITS,
    localparam int unsigned SW       = HIST_LEN + 2 * LAG + PW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  hb_adv_e              adv,
    input  logic                 a_has,
    input  logic                 a_bit,
    input  logic [PATH_BITS-1:0] a_pc,
    input  logic                 b_has,
    input  logic                 b_bit,
    input  logic [PATH_BITS-1:0] b_pc,
    input  logic                 load,
    input  logic [SW-1:0]        load_state,
    output logic [SW-1:0]        cur_state,
    output logic [HIST_LEN-1:0]  hist,
    output logic [PW-1:0]        path
);
    logic [HIST_LEN-1:0] hist_q, hist_d, hist_t;
    logic [LAG-1:0]      has_q, has_d;
    logic [LAG-1:0]      bit_q, bit_d;
    logic [PW-1:0]       pc_q, pc_d;

    // Next state for zero, one or two arriving blocks
    always_comb begin
        hist_d = hist_q;
        has_d  = has_q;
        bit_d  = bit_q;
        pc_d   = pc_q;
        hist_t = hist_q;
        case (adv)
            ADV_ONE: begin
                if (has_q[LAG-1])
                    hist_d = {hist_q[HIST_LEN-2:0], bit_q[LAG-1]};
                has_d = {has_q[LAG-2:0], b_has};
                bit_d = {bit_q[LAG-2:0], b_bit};
                pc_d  = {pc_q[(LAG-1)*PATH_BITS-1:0], b_pc};
            end
            ADV_TWO: begin
                if (has_q[LAG-1])
                    hist_t = {hist_t[HIST_LEN-2:0], bit_q[LAG-1]};
                if (has_q[LAG-2])
                    hist_t = {hist_t[HIST_LEN-2:0], bit_q[LAG-2]};
                hist_d = hist_t;
                has_d  = {has_q[LAG-3:0], a_has, b_has};
                bit_d  = {bit_q[LAG-3:0], a_bit, b_bit};
                pc_d   = {pc_q[(LAG-2)*PATH_BITS-1:0], a_pc, b_pc};
            end
            default: ;
        endcase
    end

    // State register with reset, checkpoint reload, or normal advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            has_q  <= '0;
            bit_q  <= '0;
            pc_q   <= '0;
        end else if (load) begin
            {hist_q, has_q, bit_q, pc_q} <= load_state;
        end else begin
            hist_q <= hist_d;
            has_q  <= has_d;
            bit_q  <= bit_d;
            pc_q   <= pc_d;
        end
    end

    // Expose packed state and the two visible views
    always_comb begin
        cur_state = {hist_q, has_q, bit_q, pc_q};
        hist      = hist_q;
        path      = pc_q;
    end
endmodule

// File: rtl/shr_block_hist.sv
// Top: block-compressed speculative history with three-block lag, path
// bits and a single checkpoint. Slot 0 is always the older fetch block.
module shr_block_hist
    import hb_pkg::*;
#(
    parameter int unsigned HIST_LEN  = 21,
    parameter int unsigned SLOT_W    = 3,
    parameter int unsigned PATH_BITS = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [HB_SLOTS-1:0]             blk_valid,
    input  logic [HB_SLOTS-1:0]             blk_has_cond,
    input  logic [HB_SLOTS*SLOT_W-1:0]      blk_last_slot,
    input  logic [HB_SLOTS-1:0]             blk_taken,
    input  logic [HB_SLOTS*PATH_BITS-1:0]   blk_pc_lo,
    input  logic                            snap_take,
    input  logic                            snap_restore,
    output logic [HIST_LEN-1:0]             hist_out,
    output logic [HB_LAG*PATH_BITS-1:0]     path_out
);
    localparam int unsigned PW = HB_LAG * PATH_BITS;
    localparam int unsigned SW = HIST_LEN + 2 * HB_LAG + PW;

    logic [HB_SLOTS-1:0] f_has, f_bit;
    hb_adv_e             adv;
    logic                a_has, a_bit, b_has, b_bit;
    logic [PATH_BITS-1:0] a_pc, b_pc;
    logic [SW-1:0]       live_state, saved_state;

    // One folding unit per fetch slot
    for (genvar g = 0; g < HB_SLOTS; g++) begin : g_fold
        hb_fold #(.SLOT_W(SLOT_W)) u_fold (
            .has_cond (blk_has_cond[g]),
            .last_slot(blk_last_slot[g*SLOT_W +: SLOT_W]),
            .taken    (blk_taken[g]),
            .has_bit  (f_has[g]),
            .fold_bit (f_bit[g])
        );
    end

    // Map valid slots onto older (a) and younger (b) arriving blocks
    always_comb begin
        adv   = ADV_NONE;
        a_has = f_has[0];
        a_bit = f_bit[0];
        a_pc  = blk_pc_lo[0 +: PATH_BITS];
        b_has = f_has[1];
        b_bit = f_bit[1];
        b_pc  = blk_pc_lo[PATH_BITS +: PATH_BITS];
        case (blk_valid)
            2'b11: adv = ADV_TWO;
            2'b10: adv = ADV_ONE;
            2'b01: begin
                adv   = ADV_ONE;
                b_has = f_has[0];
                b_bit = f_bit[0];
                b_pc  = blk_pc_lo[0 +: PATH_BITS];
            end
            default: adv = ADV_NONE;
        endcase
    end

    hb_window #(
        .HIST_LEN (HIST_LEN),
        .PATH_BITS(PATH_BITS),
        .LAG      (HB_LAG)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .a_has     (a_has),
        .a_bit     (a_bit),
        .a_pc      (a_pc),
        .b_has     (b_has),
        .b_bit     (b_bit),
        .b_pc      (b_pc),
        .load      (snap_restore),
        .load_state(saved_state),
        .cur_state (live_state),
        .hist      (hist_out),
        .path      (path_out)
    );

    hb_checkpoint #(.W(SW)) u_ckpt (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (snap_take),
        .live_state (live_state),
        .saved_state(saved_state)
    );
endmodule

// File: rtl/hb_checker.sv
// Port-level properties of the history register, attached by bind.
module hb_checker #(
    parameter int unsigned HIST_LEN  = 21,
    parameter int unsigned PATH_BITS = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               blk_valid,
    input logic [2*PATH_BITS-1:0]   blk_pc_lo,
    input logic                     snap_restore,
    input logic [HIST_LEN-1:0]      hist_out,
    input logic [3*PATH_BITS-1:0]   path_out
);
    localparam int unsigned PB = PATH_BITS;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (hist_out == '0 && path_out == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid == 2'b00 && !snap_restore) |=> ($stable(hist_out) && $stable(path_out))); // R4

    AST_PATH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid == 2'b01 && !snap_restore) |=>
        (path_out[PB-1:0] == $past(blk_pc_lo[PB-1:0]) &&
         path_out[3*PB-1:PB] == $past(path_out[2*PB-1:0]))); // R7

    AST_PATH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid == 2'b11 && !snap_restore) |=>
        (path_out[PB-1:0] == $past(blk_pc_lo[2*PB-1:PB]) &&
         path_out[2*PB-1:PB] == $past(blk_pc_lo[PB-1:0]) &&
         path_out[3*PB-1:2*PB] == $past(path_out[PB-1:0]))); // R6

    AST_HIST_SHIFT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid == 2'b10 && !snap_restore) |=>
        ($stable(hist_out) || hist_out[HIST_LEN-1:1] == $past(hist_out[HIST_LEN-2:0]))); // R8
endmodule

bind shr_block_hist hb_checker #(
    .HIST_LEN (HIST_LEN),
    .PATH_BITS(PATH_BITS)
) u_hb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_valid   (blk_valid),
    .blk_pc_lo   (blk_pc_lo),
    .snap_restore(snap_restore),
    .hist_out    (hist_out),
    .path_out    (path_out)
);

// File: tb/tb_shr_block_hist.sv
module tb_shr_block_hist;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  blk_valid = '0, blk_has_cond = '0, blk_taken = '0;
    logic [5:0]  blk_last_slot = '0;
    logic [3:0]  blk_pc_lo = '0;
    logic        snap_take = 1'b0, snap_restore = 1'b0;
    logic [20:0] hist_out;
    logic [5:0]  path_out;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Reference state: live and checkpoint
    logic [20:0] m_hist, s_hist;
    logic [2:0]  m_has, m_bit, s_has, s_bit;
    logic [5:0]  m_pc, s_pc;

    always #10 clk = ~clk;

    shr_block_hist dut (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_has_cond(blk_has_cond),
        .blk_last_slot(blk_last_slot), .blk_taken(blk_taken), .blk_pc_lo(blk_pc_lo),
        .snap_take(snap_take), .snap_restore(snap_restore),
        .hist_out(hist_out), .path_out(path_out)
    );

    function automatic logic fold(input logic tk, input logic [2:0] sl);
        return tk ^ (sl >= 3'd4);
    endfunction

    // Push one block into the reference window
    task automatic m_push(input logic h, input logic b, input logic [1:0] pc);
        if (m_has[2]) m_hist = {m_hist[19:0], m_bit[2]};
        m_has = {m_has[1:0], h};
        m_bit = {m_bit[1:0], b};
        m_pc  = {m_pc[3:0], pc};
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, reference update and output comparison
    task automatic step(input logic [1:0] v, input logic [1:0] hc, input logic [5:0] sl,
                        input logic [1:0] tk, input logic [3:0] pc,
                        input logic sn, input logic rs, input string tag);
        logic [20:0] o_hist; logic [2:0] o_has, o_bit; logic [5:0] o_pc;
        blk_valid = v; blk_has_cond = hc; blk_last_slot = sl; blk_taken = tk;
        blk_pc_lo = pc; snap_take = sn; snap_restore = rs;
        o_hist = m_hist; o_has = m_has; o_bit = m_bit; o_pc = m_pc;
        if (rs) begin
            m_hist = s_hist; m_has = s_has; m_bit = s_bit; m_pc = s_pc;
        end else begin
            if (v[0]) m_push(hc[0], fold(tk[0], sl[2:0]), pc[1:0]);
            if (v[1]) m_push(hc[1], fold(tk[1], sl[5:3]), pc[3:2]);
        end
        if (sn) begin
            s_hist = o_hist; s_has = o_has; s_bit = o_bit; s_pc = o_pc;
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " hist"}, 32'(hist_out), 32'(m_hist));
        chk({tag, " path"}, 32'(path_out), 32'(m_pc));
    endtask

    task automatic one(input logic hc, input logic [2:0] sl, input logic tk,
                       input logic [1:0] pc, input string tag);
        step(2'b01, {1'b0, hc}, {3'd0, sl}, {1'b0, tk}, {2'd0, pc}, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_hist = '0; m_has = '0; m_bit = '0; m_pc = '0;
        s_hist = '0; s_has = '0; s_bit = '0; s_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset hist", 32'(hist_out), 32'd0);
        chk("R1 reset path", 32'(path_out), 32'd0);

        // R2/R5: bits 1,0,1,0 then no-branch blocks to flush the lag
        one(1'b1, 3'd2, 1'b1, 2'd1, "R2");
        one(1'b1, 3'd5, 1'b1, 2'd2, "R2");
        one(1'b1, 3'd7, 1'b0, 2'd3, "R2");
        chk("R5 bit still hidden", 32'(hist_out), 32'd0);
        chk("R7 path order", 32'(path_out), 32'(6'b011011));
        one(1'b1, 3'd0, 1'b0, 2'd0, "R5");
        chk("R5 first bit visible", 32'(hist_out), 32'd1);
        one(1'b0, 3'd6, 1'b1, 2'd1, "R3");
        one(1'b0, 3'd6, 1'b1, 2'd2, "R3");
        one(1'b0, 3'd6, 1'b1, 2'd3, "R3");
        chk("R2 folded pattern", 32'(hist_out), 32'(4'b1010));
        one(1'b0, 3'd1, 1'b0, 2'd0, "R3");
        chk("R3 no-branch retire adds nothing", 32'(hist_out), 32'(4'b1010));

        // R4: idle cycles hold state
        step(2'b00, 2'b11, 6'o77, 2'b11, 4'hF, 1'b0, 1'b0, "R4");
        chk("R4 idle hist", 32'(hist_out), 32'(4'b1010));

        // R11: lone slot 1
        step(2'b10, 2'b10, 6'o40, 2'b10, 4'b1100, 1'b0, 1'b0, "R11");
        chk("R11 slot1 path", 32'(path_out[1:0]), 32'd3);

        // R6: two blocks per cycle, older first
        step(2'b11, 2'b11, 6'o05, 2'b01, 4'b0110, 1'b0, 1'b0, "R6");
        chk("R6 younger at bits1:0", 32'(path_out[3:0]), 32'(4'b1001));
        step(2'b11, 2'b11, 6'o16, 2'b10, 4'b1101, 1'b0, 1'b0, "R6");

        // R8: fill past the length with ones
        for (int i = 0; i < 26; i++) one(1'b1, 3'd0, 1'b1, 2'(i), "R8");
        chk("R8 saturated ones", 32'(hist_out), 32'h1F_FFFF);

        // R9: checkpoint, advance, restore with blocks ignored
        step(2'b00, 2'b00, 6'd0, 2'b00, 4'd0, 1'b1, 1'b0, "R9");
        for (int i = 0; i < 5; i++) one(1'b1, 3'd1, 1'b0, 2'd2, "R9");
        step(2'b11, 2'b11, 6'd0, 2'b00, 4'hA, 1'b0, 1'b1, "R9");
        chk("R9 restored hist", 32'(hist_out), 32'h1F_FFFF);

        // R10: snapshot and restore together
        for (int i = 0; i < 4; i++) one(1'b1, 3'd3, 1'b0, 2'd1, "R10");
        step(2'b01, 2'b01, 6'd0, 2'b01, 4'd2, 1'b1, 1'b1, "R10");
        step(2'b00, 2'b00, 6'd0, 2'b00, 4'd0, 1'b0, 1'b1, "R10");

        // Random mix covering R2, R3, R6, R8, R9, R11
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[1:0], r[3:2], r[9:4], r[11:10], r[15:12],
                 r[19:16] == 4'd0, r[23:20] == 4'd0, "R6 R8 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule